// File: doc/BRIEF.md
# Prescaled Periodic Interrupt Timer

This block is a memory-mapped down-counter that produces a periodic level interrupt. Software programs a 16-bit modulus and a control word. The counter then decrements at a rate set by a power-of-two prescaler fed from half the system clock. When the counter reaches zero and the next tick arrives, the counter either reloads from the modulus or wraps to 0xFFFF and keeps running. In the same cycle it sets a sticky flag. The interrupt line is high whenever that flag and the interrupt enable are both set.

A small register bus reaches three 16-bit registers: control/status at byte offset 0x0, modulus at 0x2 and the read-only live count at 0x4. Each access uses a byte address, a write strobe, write data and combinational read data. Software clears the flag by writing a one to it. Setting the overwrite bit makes a modulus write load the counter at once. A control write that touches only the interrupt-enable or flag bits leaves the running count and prescaler phase alone. The two halt-mode bits are stored but have no effect.

Top module: `pit_timer`

## Requirements
- R1: The control register holds enable in bit 0, reload in bit 1, flag in bit 2, interrupt enable in bit 3, overwrite in bit 4, two stored-only halt bits in bits 5 and 6, and the prescaler select PRE in bits 11:8. Bits 7 and 15:12 read as 0.
- R2: After reset the control register reads 0x0000, the modulus reads 0xFFFF, the count reads 0xFFFF and the interrupt is low.
- R3: Writing a control word with bit 2 set clears the flag. Writing it with bit 2 clear leaves the flag as it was.
- R4: The interrupt output is high exactly when the interrupt enable and the flag are both 1.
- R5: While enabled, the count decrements once every 2*2^PRE clock cycles. The first decrement comes 2*2^PRE cycles after the restart.
- R6: In reload mode (bit 1 = 1), a tick that finds the count at 0 loads the modulus and sets the flag in the same cycle.
- R7: In free-running mode (bit 1 = 0), a tick that finds the count at 0 loads 0xFFFF and sets the flag.
- R8: A modulus write always stores the new limit. With overwrite set, it also loads the count at once in either mode. Without overwrite, the count is not touched, and in reload mode the new value first appears at the next reload.
- R9: While enable is 0 the count holds. A control write that changes enable or PRE restarts the prescaler and loads the count from the limit: the modulus if the written reload bit is 1, otherwise 0xFFFF.
- R10: A control write that changes neither enable nor PRE does not disturb the count or the prescaler phase.
- R11: A read at offset 0x4 returns the live count. Writes to 0x4 or to unmapped offsets change nothing, and reads of unmapped offsets return 0.
- R12: If an expiry and a flag-clear write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at bus_addr (combinational) |
| irq_out | output | 1 | Level interrupt request |

## Verification
Countdown is exercised in reload mode with a small modulus, in free-running mode after an overwrite load, with a deferred modulus change, and with a prescaler of 2. The last of these separates the divide-by-two-per-step rate from an off-by-one in the terminal count. A flag-clear write is timed to land on a decrement edge, so a control write that wrongly restarts the prescaler shows up as a stale count. A second flag-clear write coincides with an expiry, which exposes the wrong priority between clearing and setting the flag. Writes to the count register and to an unmapped offset are followed by readbacks that would reveal any corruption.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int DATA_W = 16;
  localparam int PRE_W  = 4;
  localparam int PSC_W  = 1 << PRE_W;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_MOD  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 3'd4;

  // control bit positions (software visible)
  localparam int B_EN   = 0;
  localparam int B_RLD  = 1;
  localparam int B_FLAG = 2;
  localparam int B_IE   = 3;
  localparam int B_OVW  = 4;
  localparam int B_DBG  = 5;
  localparam int B_DOZE = 6;
  localparam int B_PRE  = 8;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             doze;
    logic             dbg;
    logic             ovw;
    logic             ie;
    logic             rld;
    logic             en;
  } pit_cfg_t;

  // last value of the prescale counter: 2*2^pre - 1
  function automatic logic [PSC_W-1:0] pit_terminal(input logic [PRE_W-1:0] pre);
    logic [PRE_W:0] sh;
    sh = {1'b0, pre} + 1'b1;
    return ~({PSC_W{1'b1}} << sh);
  endfunction

  // value the counter is loaded with on reload, wrap or restart
  function automatic logic [DATA_W-1:0] pit_limit(input logic rld,
                                                  input logic [DATA_W-1:0] modulus);
    return rld ? modulus : {DATA_W{1'b1}};
  endfunction

  function automatic pit_cfg_t pit_unpack(input logic [DATA_W-1:0] w);
    pit_cfg_t c;
    c.en   = w[B_EN];
    c.rld  = w[B_RLD];
    c.ie   = w[B_IE];
    c.ovw  = w[B_OVW];
    c.dbg  = w[B_DBG];
    c.doze = w[B_DOZE];
    c.pre  = w[B_PRE +: PRE_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pit_pack(input pit_cfg_t c, input logic flag);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_EN]            = c.en;
    w[B_RLD]           = c.rld;
    w[B_FLAG]          = flag;
    w[B_IE]            = c.ie;
    w[B_OVW]           = c.ovw;
    w[B_DBG]           = c.dbg;
    w[B_DOZE]          = c.doze;
    w[B_PRE +: PRE_W]  = c.pre;
    return w;
  endfunction

endpackage

// File: rtl/pit_ctrl_reg.sv
module pit_ctrl_reg
  import pit_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_ctrl,
  input  pit_cfg_t cfg_in,
  input  logic     flag_clr_bit,
  input  logic     expire,
  output pit_cfg_t cfg,
  output logic     flag,
  output logic     restart
);

  // restart only when the enable or the prescaler select actually changes
  assign restart = wr_ctrl && ((cfg_in.en != cfg.en) || (cfg_in.pre != cfg.pre));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_ctrl) begin
      cfg <= cfg_in;
    end
  end

  // set by expiry, cleared by write-one; expiry has priority
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (expire) begin
      flag <= 1'b1;
    end else if (wr_ctrl && flag_clr_bit) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler
  import pit_pkg::*;
#(
  parameter int P_W = PRE_W,
  parameter int C_W = PSC_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [P_W-1:0] pre,
  input  logic           restart,
  output logic           tick
);

  logic [C_W-1:0] phase;
  logic           at_term;

  assign at_term = (phase == pit_terminal(pre));
  assign tick    = run && at_term && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart || !run || at_term) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_mod,
  input  logic [W-1:0] wdata,
  input  logic         ovw,
  input  logic         rld,
  input  logic         restart,
  input  logic         restart_rld,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic [W-1:0] modulus,
  output logic         expire,
  output logic         ovw_load
);

  assign expire   = tick && (count == '0);
  assign ovw_load = wr_mod && ovw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modulus <= '1;
    end else if (wr_mod) begin
      modulus <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '1;
    end else if (restart) begin
      count <= pit_limit(restart_rld, modulus);
    end else if (ovw_load) begin
      count <= wdata;
    end else if (expire) begin
      count <= pit_limit(rld, modulus);
    end else if (tick) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  pit_cfg_t          cfg;
  pit_cfg_t          cfg_in;
  logic              flag;
  logic              restart;
  logic              tick;
  logic              expire;
  logic              ovw_load;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] modulus;
  logic              wr_ctrl;
  logic              wr_mod;

  // named internal events for the checker
  logic cfg_en, cfg_rld, cfg_ie;
  assign cfg_en  = cfg.en;
  assign cfg_rld = cfg.rld;
  assign cfg_ie  = cfg.ie;

  assign wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
  assign wr_mod  = bus_we && (bus_addr == OFF_MOD);
  assign cfg_in  = pit_unpack(bus_wdata);

  pit_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr_ctrl),
    .cfg_in       (cfg_in),
    .flag_clr_bit (bus_wdata[B_FLAG]),
    .expire       (expire),
    .cfg          (cfg),
    .flag         (flag),
    .restart      (restart)
  );

  pit_prescaler #(.P_W(PRE_W), .C_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg.en),
    .pre     (cfg.pre),
    .restart (restart),
    .tick    (tick)
  );

  pit_counter #(.W(DATA_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_mod      (wr_mod),
    .wdata       (bus_wdata),
    .ovw         (cfg.ovw),
    .rld         (cfg.rld),
    .restart     (restart),
    .restart_rld (cfg_in.rld),
    .tick        (tick),
    .count       (count),
    .modulus     (modulus),
    .expire      (expire),
    .ovw_load    (ovw_load)
  );

  always_comb begin
    case (bus_addr)
      OFF_CTRL: bus_rdata = pit_pack(cfg, flag);
      OFF_MOD:  bus_rdata = modulus;
      OFF_CNT:  bus_rdata = count;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_out = flag & cfg.ie;

endmodule

// File: rtl/pit_timer_checker.sv
module pit_timer_checker
  import pit_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              irq_out,
  input logic              tick,
  input logic              expire,
  input logic              restart,
  input logic              ovw_load,
  input logic              en,
  input logic              rld,
  input logic              ie,
  input logic              flag,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] modulus
);

  // R4: interrupt follows flag and enable
  p_irq_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ie) |-> irq_out);
  p_irq_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq_out);

  // R5: no prescaled tick while disabled
  p_tick_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);

  // R6: expiry sets the flag
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  // R6: reload from modulus
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rld && !ovw_load) |=> (count == $past(modulus)));

  // R7: wrap to all ones
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !rld && !ovw_load) |=> (count == {DATA_W{1'b1}}));

  // R9: count holds while disabled
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart && !ovw_load) |=> $stable(count));

  // R5: each non-expiring tick decrements by one
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !expire && !ovw_load) |=> (count == $past(count) - 1'b1));

endmodule

bind pit_timer pit_timer_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_out  (irq_out),
  .tick     (tick),
  .expire   (expire),
  .restart  (restart),
  .ovw_load (ovw_load),
  .en       (cfg_en),
  .rld      (cfg_rld),
  .ie       (cfg_ie),
  .flag     (flag),
  .count    (count),
  .modulus  (modulus)
);

// File: tb/pit_timer_test.sv
module pit_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MOD  = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  pit_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic expect_irq(input string req, input logic exp);
    chk(req, {15'd0, irq_out}, {15'd0, exp});
  endtask

  // drive at a falling edge, commit on the rising edge, return at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    expect_reg("R2 ctrl", A_CTRL, 16'h0000);
    expect_reg("R2 mod",  A_MOD,  16'hFFFF);
    expect_reg("R2 cnt",  A_CNT,  16'hFFFF);
    expect_irq("R2 irq", 1'b0);
  endtask

  task automatic t_reload;
    wr(A_MOD, 16'd3);
    wr(A_CTRL, 16'h000B);                 // edge 0: en, rld, ie, pre 0
    expect_reg("R9 restart load", A_CNT, 16'd3);
    wait_edges(1);
    expect_reg("R5 no step yet", A_CNT, 16'd3);
    wait_edges(1);
    expect_reg("R5 first step", A_CNT, 16'd2);
    wait_edges(5);                        // edge 7
    expect_reg("R6 at zero", A_CNT, 16'd0);
    expect_irq("R4 irq before expiry", 1'b0);
    wait_edges(1);                        // edge 8
    expect_reg("R6 reload", A_CNT, 16'd3);
    expect_reg("R6 flag set", A_CTRL, 16'h000F);
    expect_irq("R4 irq raised", 1'b1);
    wr(A_CTRL, 16'h000B);                 // edge 9, flag bit 0
    expect_reg("R3 write zero keeps flag", A_CTRL, 16'h000F);
    wr(A_CTRL, 16'h000F);                 // edge 10, tick lands here
    expect_reg("R10 count undisturbed", A_CNT, 16'd2);
    expect_reg("R3 flag cleared", A_CTRL, 16'h000B);
    expect_irq("R4 irq dropped", 1'b0);
  endtask

  task automatic t_freerun;
    wr(A_CTRL, 16'h0000);
    wr(A_CTRL, 16'h0011);                 // edge 0: en, ovw, free-run
    expect_reg("R9 free-run restart", A_CNT, 16'hFFFF);
    wr(A_MOD, 16'd1);                     // edge 1
    expect_reg("R8 overwrite load", A_CNT, 16'd1);
    expect_reg("R8 mod stored", A_MOD, 16'd1);
    wait_edges(2);                        // edge 3
    expect_reg("R7 at zero", A_CNT, 16'd0);
    wait_edges(1);                        // edge 4
    expect_reg("R7 wrap", A_CNT, 16'hFFFF);
    expect_reg("R7 flag set", A_CTRL, 16'h0015);
    expect_irq("R4 masked irq", 1'b0);
    wait_edges(2);
    expect_reg("R7 keeps running", A_CNT, 16'hFFFE);
  endtask

  task automatic t_deferred;
    wr(A_CTRL, 16'h0000);
    wr(A_MOD, 16'd2);
    wr(A_CTRL, 16'h0003);                 // edge 0
    expect_reg("R9 load", A_CNT, 16'd2);
    wr(A_MOD, 16'd5);                     // edge 1, no overwrite
    expect_reg("R8 count untouched", A_CNT, 16'd2);
    expect_reg("R8 new mod", A_MOD, 16'd5);
    wait_edges(5);                        // edge 6 expiry
    expect_reg("R8 new limit at reload", A_CNT, 16'd5);
    wr(A_CTRL, 16'h0013);                 // set overwrite, no restart
    wr(A_MOD, 16'd7);
    expect_reg("R8 overwrite in reload mode", A_CNT, 16'd7);
  endtask

  task automatic t_prescale;
    wr(A_CTRL, 16'h0000);
    wr(A_MOD, 16'd1);
    wr(A_CTRL, 16'h0203);                 // edge 0, PRE=2 -> 8 cycles per step
    wait_edges(7);
    expect_reg("R5 PRE2 before step", A_CNT, 16'd1);
    wait_edges(1);
    expect_reg("R5 PRE2 step", A_CNT, 16'd0);
    wait_edges(8);
    expect_reg("R5 PRE2 reload", A_CNT, 16'd1);
  endtask

  task automatic t_disable;
    wr(A_CTRL, 16'h0F7C);
    expect_reg("R1 field layout", A_CTRL, 16'h0F78);
    wr(A_CTRL, 16'hF082);
    expect_reg("R1 reserved bits", A_CTRL, 16'h0002);
    expect_reg("R9 disable load", A_CNT, 16'd1);
    wait_edges(10);
    expect_reg("R9 hold while disabled", A_CNT, 16'd1);
    wr(A_CNT, 16'h1234);
    expect_reg("R11 count write ignored", A_CNT, 16'd1);
    expect_reg("R11 mod unchanged", A_MOD, 16'd1);
    wr(3'd6, 16'h5555);
    expect_reg("R11 unmapped write ctrl", A_CTRL, 16'h0002);
    expect_reg("R11 unmapped write cnt", A_CNT, 16'd1);
    expect_reg("R11 unmapped read", 3'd6, 16'h0000);
  endtask

  task automatic t_race;
    wr(A_CTRL, 16'h0000);
    wr(A_MOD, 16'd0);
    wr(A_CTRL, 16'h000B);                 // edge 0, count 0
    wait_edges(3);                        // expiry at edge 2
    expect_reg("R6 flag from zero modulus", A_CTRL, 16'h000F);
    wr(A_CTRL, 16'h0007);                 // edge 4: clear + expiry, ie off
    expect_reg("R12 expiry wins", A_CTRL, 16'h0007);
    expect_irq("R4 ie off", 1'b0);
    wr(A_CTRL, 16'h000F);                 // edge 5: no tick
    expect_reg("R3 clear without expiry", A_CTRL, 16'h000B);
    wait_edges(1);                        // edge 6 expiry
    expect_irq("R4 irq again", 1'b1);
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reload();
    t_freerun();
    t_deferred();
    t_prescale();
    t_disable();
    t_race();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

endmodule